// File: doc/BRIEF.md
# Step Attenuator Control Logic

This block is the digital control front end of a six-bit step attenuator with half-decibel resolution. It produces the attenuation word that drives the switched attenuator array. The word can come from three places: the six parallel control pins, either followed directly or captured by a latch enable pulse; a serial shift register loaded through a data and clock pair and passed on by a transparent latch; or a power-up initialisation path. A mode input selects between the parallel and serial interfaces.

All control pins are asynchronous to the system clock. Each passes through a two-stage synchroniser, and the serial clock and latch enable edges are found from the synchronised copies. Release of the active-low reset is the power-up event. While reset is held, the block keeps the word at zero. Once the synchronisers have filled, it loads a starting word that depends on the mode pin, the latch enable pin and a two-bit preset select.

Top module: `step_atten_ctrl`

## Requirements
- R1: `atten_o` bit 5 weighs 16 dB, bit 4 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB. All zeros is reference loss and all ones is 31.5 dB.
- R2: `atten_o` is zero while `rst_ni` is low. It stays zero through the first two rising clock edges after release, and the power-up word appears after the third.
- R3: If `ser_mode_i` is high at power-up, the power-up word is `par_word_i`.
- R4: If `ser_mode_i` is low and `latch_en_i` is high at power-up, the power-up word is `par_word_i` and `preset_i` has no effect.
- R5: If `ser_mode_i` and `latch_en_i` are both low at power-up, `preset_i` selects the word: 2'b00 gives 000000, 2'b01 gives 010000 (8 dB), 2'b10 gives 100000 (16 dB) and 2'b11 gives 111110 (31 dB).
- R6: Each rising edge of `sclk_i` shifts `sdata_i` into the LSB of the six-bit shift register, whatever the level of `latch_en_i`. After six shifts, the first bit sent sits in bit 5.
- R7: With `ser_mode_i` high and `latch_en_i` high, `atten_o` follows the shift register contents.
- R8: While `latch_en_i` stays low, `atten_o` does not change, whatever happens on `par_word_i` or the serial pins.
- R9: With `ser_mode_i` low and `latch_en_i` high, `atten_o` follows `par_word_i` within three clock cycles.
- R10: When `latch_en_i` falls, the value then selected (the parallel pins in parallel mode, the shift register in serial mode) is kept on `atten_o`.
- R11: A preset word loaded at power-up stays on `atten_o` until `latch_en_i` is next raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release is the power-up event |
| ser_mode_i | input | 1 | 0 selects the parallel interface, 1 selects the serial interface |
| par_word_i | input | WORD_W | Parallel attenuation control bits, MSB is 16 dB |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| latch_en_i | input | 1 | Latch enable: transparent when high, holds when low |
| preset_i | input | 2 | Power-up preset select used in parallel mode with latch enable low |
| atten_o | output | WORD_W | Attenuation word to the switch array |

## Verification
The power-up paths are the hardest to reach. Each one exists only in the few cycles after reset release, and the pins must already be held at the chosen mode, latch level and preset select. The bench therefore re-enters reset once for every power-up case, with the pins set up beforehand. It checks the zero word one cycle before the load and the loaded word one cycle after. After a preset load it moves the parallel pins with the latch held low, to show that the preset holds until the latch is raised. It also shifts a full word with the latch low, to show that shifting goes on unseen until the latch opens.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [1:0] {
    PRE_REF  = 2'b00,
    PRE_NEXT = 2'b01,
    PRE_TOP  = 2'b10,
    PRE_FULL = 2'b11
  } preset_e;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st_q <= '0;
      else         st_q <= d_i;
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st_q <= '0;
      else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/atten_init.sv
module atten_init #(
  parameter int SETTLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic done_o
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          full;

  assign full = (cnt_q == CW'(SETTLE));

  // wait for the synchronisers to fill, then load once
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (full) done_q <= 1'b1;
      else      cnt_q  <= cnt_q + 1'b1;
    end

  assign load_o = !done_q && full;
  assign done_o = done_q;
endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         sclk_i,
  input  logic         sdata_i,
  output logic         rise_o,
  output logic [W-1:0] shreg_o
);
  logic         sclk_p_q;
  logic [W-1:0] shreg_q;

  assign rise_o = sclk_i && !sclk_p_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_p_q <= 1'b0;
    else         sclk_p_q <= sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              shreg_q <= '0;
    else if (load_i)          shreg_q <= load_val_i;
    else if (en_i && rise_o)  shreg_q <= {shreg_q[W-2:0], sdata_i};

  assign shreg_o = shreg_q;
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
#(
  parameter int WORD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_mode_i,
  input  logic [WORD_W-1:0] par_word_i,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              latch_en_i,
  input  logic [1:0]        preset_i,
  output logic [WORD_W-1:0] atten_o
);
  localparam int CTRL_W = WORD_W + 6;

  logic [CTRL_W-1:0] raw, synced;
  logic              mode_s, sdata_s, sclk_s, le_s;
  logic [1:0]        pre_s;
  logic [WORD_W-1:0] par_s;
  logic              init_load, init_done;
  logic              sclk_rise;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] init_word;
  logic              le_p_q, le_fall;
  logic [WORD_W-1:0] atten_q;

  assign raw = {ser_mode_i, sdata_i, sclk_i, latch_en_i, preset_i, par_word_i};

  atten_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {mode_s, sdata_s, sclk_s, le_s, pre_s, par_s} = synced;

  atten_init #(.SETTLE(SYNC_STAGES)) u_init (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_o(init_load),
    .done_o(init_done)
  );

  atten_shift #(.W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (init_done),
    .load_i    (init_load),
    .load_val_i(par_s),
    .sclk_i    (sclk_s),
    .sdata_i   (sdata_s),
    .rise_o    (sclk_rise),
    .shreg_o   (shreg)
  );

  function automatic logic [WORD_W-1:0] preset_word(input preset_e sel);
    logic [WORD_W-1:0] w;
    case (sel)
      PRE_REF:  w = '0;
      PRE_NEXT: w = WORD_W'(1) << (WORD_W - 2);
      PRE_TOP:  w = WORD_W'(1) << (WORD_W - 1);
      default:  w = ~WORD_W'(1);
    endcase
    return w;
  endfunction

  always_comb
    if (mode_s || le_s) init_word = par_s;
    else                init_word = preset_word(preset_e'(pre_s));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) le_p_q <= 1'b0;
    else         le_p_q <= le_s;

  assign le_fall = le_p_q && !le_s;

  // transparent while le high, capture on the falling edge, hold otherwise
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                             atten_q <= '0;
    else if (init_load)                      atten_q <= init_word;
    else if (init_done && (le_s || le_fall)) atten_q <= mode_s ? shreg : par_s;

  assign atten_o = atten_q;
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
  parameter int W = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         done_i,
  input logic         mode_i,
  input logic         le_i,
  input logic         le_prev_i,
  input logic         sclk_rise_i,
  input logic         sdata_i,
  input logic [W-1:0] par_i,
  input logic [W-1:0] shreg_i,
  input logic [W-1:0] atten_i
);
  // R2
  zero_before_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> atten_i == '0);

  // R6
  shift_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && sclk_rise_i) |=> shreg_i == {$past(shreg_i[W-2:0]), $past(sdata_i)});

  // R7
  serial_transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && mode_i && le_i) |=> atten_i == $past(shreg_i));

  // R9
  direct_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !mode_i && le_i) |=> atten_i == $past(par_i));

  // R8
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !le_i && !le_prev_i) |=> $stable(atten_i));
endmodule

bind step_atten_ctrl atten_ctrl_chk #(.W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_i     (init_done),
  .mode_i     (mode_s),
  .le_i       (le_s),
  .le_prev_i  (le_p_q),
  .sclk_rise_i(sclk_rise),
  .sdata_i    (sdata_s),
  .par_i      (par_s),
  .shreg_i    (shreg),
  .atten_i    (atten_o)
);

// File: tb/step_atten_ctrl_test.sv
`timescale 1ns/1ps
module step_atten_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_mode = 1'b0;
  logic [5:0] par_word = '0;
  logic       sdata = 1'b0;
  logic       sclk = 1'b0;
  logic       latch_en = 1'b0;
  logic [1:0] preset = '0;
  logic [5:0] atten;

  int total = 0;
  int bad   = 0;
  logic [5:0] shadow;

  always #2.5 clk = ~clk;

  step_atten_ctrl uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .ser_mode_i(ser_mode),
    .par_word_i(par_word),
    .sdata_i   (sdata),
    .sclk_i    (sclk),
    .latch_en_i(latch_en),
    .preset_i  (preset),
    .atten_o   (atten)
  );

  // {mode, par, serial word, expected}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 6'b000000, 6'b111111, 6'b000000},  // R1 reference
    {1'b0, 6'b111111, 6'b000000, 6'b111111},  // R1 full scale
    {1'b1, 6'b000000, 6'b100000, 6'b100000},  // R6 first bit lands in MSB
    {1'b1, 6'b111111, 6'b000001, 6'b000001},
    {1'b0, 6'b101010, 6'b010101, 6'b101010},
    {1'b1, 6'b101010, 6'b010101, 6'b010101},
    {1'b1, 6'b000000, 6'b110011, 6'b110011},
    {1'b0, 6'b011001, 6'b111000, 6'b011001}
  };

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic power_up(input logic m, input logic le, input logic [1:0] pre,
                          input logic [5:0] par, input logic [5:0] exp, input string tag);
    @(negedge clk);
    rst_ni = 1'b0;
    ser_mode = m; latch_en = le; preset = pre; par_word = par;
    sclk = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 in reset", atten, 6'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 before load", atten, 6'b0);
    @(negedge clk);
    check(tag, atten, exp);
  endtask

  task automatic shift_bit(input logic b);
    sdata = b; settle();
    sclk = 1'b1; settle();
    sclk = 1'b0; settle();
  endtask

  task automatic shift_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_le();
    latch_en = 1'b1; settle();
    latch_en = 1'b0; settle();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hang exp=done");
    finish_run();
  end

  initial begin
    // R5 preset table, parallel pins ignored
    power_up(1'b0, 1'b0, 2'b00, 6'b111111, 6'b000000, "R5 preset 00");
    power_up(1'b0, 1'b0, 2'b01, 6'b000000, 6'b010000, "R5 preset 01");
    power_up(1'b0, 1'b0, 2'b10, 6'b000000, 6'b100000, "R5 preset 10");
    power_up(1'b0, 1'b0, 2'b11, 6'b000000, 6'b111110, "R5 preset 11");
    // R3 serial power-up loads parallel pins
    power_up(1'b1, 1'b0, 2'b11, 6'b101101, 6'b101101, "R3 serial power-up");
    // R4 parallel with latch high, preset ignored
    power_up(1'b0, 1'b1, 2'b11, 6'b010011, 6'b010011, "R4 direct power-up");

    // R11 preset held while latch stays low
    power_up(1'b0, 1'b0, 2'b10, 6'b000111, 6'b100000, "R5 preset 10 again");
    par_word = 6'b111000; settle();
    check("R11 preset held", atten, 6'b100000);
    latch_en = 1'b1; settle();
    check("R9 direct follow a", atten, 6'b111000);
    par_word = 6'b000101; settle();
    check("R9 direct follow b", atten, 6'b000101);
    latch_en = 1'b0; settle();
    par_word = 6'b110110; settle();
    check("R10 parallel capture at fall", atten, 6'b000101);

    // table walk: shift with latch low, then pulse
    for (int i = 0; i < 8; i++) begin
      logic [5:0] prev;
      prev = atten;
      latch_en = 1'b0;
      par_word = VEC[i][17:12];
      ser_mode = VEC[i][18];
      shift_word(VEC[i][11:6]);
      check("R8 no change while latch low", atten, prev);
      pulse_le();
      check("R10 R1 R6 table entry", atten, VEC[i][5:0]);
    end

    // R7 serial transparent, shift by shift
    shadow = VEC[7][11:6];
    ser_mode = 1'b1; latch_en = 1'b1; settle();
    check("R7 transparent initial", atten, shadow);
    shift_bit(1'b1); shadow = {shadow[4:0], 1'b1};
    check("R7 transparent shift 1", atten, shadow);
    shift_bit(1'b0); shadow = {shadow[4:0], 1'b0};
    check("R7 transparent shift 0", atten, shadow);

    // R6 shifting continues with latch low
    latch_en = 1'b0; settle();
    shift_word(6'b011110);
    check("R8 serial hold", atten, shadow);
    latch_en = 1'b1; settle();
    check("R6 shift independent of latch", atten, 6'b011110);
    latch_en = 1'b0; settle();
    par_word = 6'b000000; settle();
    check("R10 serial hold after fall", atten, 6'b011110);

    finish_run();
  end
endmodule